// File: doc/BRIEF.md
# Asynchronous Operation Group Tracker

This block keeps track of asynchronous operations that an execution unit works on in the background. A requester announces each operation it launches with a one-cycle issue pulse. A commit pulse gathers every operation launched since the previous commit into a new group. Groups are kept in issue order in a small circular queue, and each entry counts how many of its operations are still outstanding. The execution unit reports each finished operation with a completion pulse. That pulse carries the queue slot of the group the operation belongs to.

A requester that must not go on until enough work has drained sends a wait request with a count N. The tracker stalls the requester until every group except the N most recently committed ones has finished. It then pulses a done signal. Commit and wait requests are only valid when every lane of the requester agrees. A request marked as non-uniform is dropped and raises a sticky error flag. When the queue is full, the tracker refuses new commits and signals backpressure.

Top module: `async_group_tracker`

## Requirements
- R1: An accepted commit creates one group whose outstanding count equals the operations issued since the previous accepted commit, counting an issue pulse in the same cycle. The uncommitted tally then restarts from zero. Operations whose commit was refused stay uncommitted and join the next accepted group.
- R2: A commit with no uncommitted operations still occupies a queue slot, as a group with zero outstanding operations, and that group counts as complete at once.
- R3: A wait with count N is satisfied when every committed group other than the N newest has zero outstanding operations. Pending groups among the N newest do not block it.
- R4: A wait with N = 0 is satisfied only when every committed group has zero outstanding operations.
- R5: `wait_done_o` is high for exactly the one cycle in which an active wait first finds its condition true. If the condition already holds in the cycle the request arrives, the pulse occurs in that same cycle. The condition uses the queue state registered before that cycle's commit and completion inputs take effect.
- R6: `stall_o` is high in every cycle in which a wait is active and its condition is false. A request arriving while a wait is already active is ignored.
- R7: `full_o` is high while all DEPTH slots hold groups. A commit in that state is not accepted.
- R8: Groups leave the queue only from the oldest end, one per cycle, and only once their count is zero. A completion for a younger group lowers that group's count but does not free its slot.
- R9: A commit or wait presented with `lane_mismatch_i` high is dropped, and `err_o` goes high one cycle later and stays high until reset.
- R10: `pending_o` gives the number of committed groups with a non-zero count. Issued but uncommitted operations are not included.
- R11: Group slots are handed out in sequence, starting at slot 0 after reset and wrapping modulo DEPTH. A completion's tag names that slot. A completion that names an empty slot or a group whose count is already zero has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | One operation launched this cycle |
| commit_i | input | 1 | Close the open batch into a new group |
| wait_req_i | input | 1 | Wait request |
| wait_n_i | input | $clog2(DEPTH+1) | Number of newest groups allowed to stay pending |
| lane_mismatch_i | input | 1 | Lanes disagree on the commit or wait in this cycle |
| cpl_i | input | 1 | One operation finished |
| cpl_tag_i | input | $clog2(DEPTH) | Queue slot of the finished operation's group |
| stall_o | output | 1 | Requester must hold |
| wait_done_o | output | 1 | Wait condition satisfied, one-cycle pulse |
| pending_o | output | $clog2(DEPTH+1) | Groups with outstanding operations |
| full_o | output | 1 | Queue full, commits refused |
| err_o | output | 1 | Sticky non-uniform request flag |

## Verification
On every cycle, the assertions check the following:
- A stall resolves only into more stall or into a done pulse.
- The error flag never clears.
- No group is written into a full queue.
- The oldest slot is occupied whenever the queue is not empty.
- The pending count never exceeds the occupancy.
- The open tally never overflows.

The bench scenarios show the remaining behaviour:
- The N-newest rule.
- Same-cycle completion of a wait on a queue that has already drained.
- Empty groups.
- A completion for a younger group that leaves it in place.
- A commit refused while the queue is full, whose operations carry over.
- Dropped non-uniform requests.

// File: rtl/agt_pkg.sv
package agt_pkg;
   typedef enum logic [0:0] {
      WAIT_IDLE = 1'b0,
      WAIT_HOLD = 1'b1
   } wait_state_e;
endpackage

// File: rtl/agt_group_queue.sv
module agt_group_queue #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 6,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [CNT_W-1:0] push_cnt_i,
   input  logic             cpl_i,
   input  logic [PTR_W-1:0] cpl_tag_i,
   output logic [DEPTH-1:0] slot_vld_o,
   output logic [CNT_W-1:0] slot_cnt_o [DEPTH],
   output logic [PTR_W-1:0] tail_o,
   output logic [OCC_W-1:0] occ_o,
   output logic             full_o
);
   logic [PTR_W-1:0] head_q, tail_q;
   logic [OCC_W-1:0] occ_q;
   logic             retire;

   assign retire = slot_vld_o[head_q] && (slot_cnt_o[head_q] == '0);
   assign full_o = (occ_q == OCC_W'(DEPTH));
   assign tail_o = tail_q;
   assign occ_o  = occ_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic             vld_q;
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            cnt_q <= '0;
         end else if (push_i && tail_q == PTR_W'(g)) begin
            vld_q <= 1'b1;
            cnt_q <= push_cnt_i;
         end else if (retire && head_q == PTR_W'(g)) begin
            vld_q <= 1'b0;
         end else if (cpl_i && cpl_tag_i == PTR_W'(g) && vld_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
      assign slot_vld_o[g] = vld_q;
      assign slot_cnt_o[g] = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
      end else begin
         if (push_i) tail_q <= tail_q + 1'b1;
         if (retire) head_q <= head_q + 1'b1;
         occ_q <= occ_q + OCC_W'(push_i) - OCC_W'(retire);
      end
   end

   // R7: the control never writes a group into a full queue
   a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !push_i);
   // R8: in-order retirement keeps the oldest slot occupied while not empty
   a_r8_head_occupied: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_q != '0) |-> slot_vld_o[head_q]);
endmodule

// File: rtl/agt_wait_eval.sv
module agt_wait_eval #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 6,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic [DEPTH-1:0] slot_vld_i,
   input  logic [CNT_W-1:0] slot_cnt_i [DEPTH],
   input  logic [PTR_W-1:0] tail_i,
   input  logic [OCC_W-1:0] keep_n_i,
   output logic             cond_o,
   output logic [OCC_W-1:0] pending_o
);
   logic [DEPTH-1:0] blocker;
   logic [DEPTH-1:0] busy;

   for (genvar g = 0; g < DEPTH; g++) begin : g_age
      logic [PTR_W-1:0] age;
      assign age        = tail_i - PTR_W'(g) - 1'b1;
      assign busy[g]    = slot_vld_i[g] && (slot_cnt_i[g] != '0);
      assign blocker[g] = busy[g] && (OCC_W'(age) >= keep_n_i);
   end

   assign cond_o = (blocker == '0);

   always_comb begin
      pending_o = '0;
      for (int i = 0; i < DEPTH; i++) pending_o = pending_o + OCC_W'(busy[i]);
   end
endmodule

// File: rtl/async_group_tracker.sv
module async_group_tracker #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 6,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_i,
   input  logic             commit_i,
   input  logic             wait_req_i,
   input  logic [OCC_W-1:0] wait_n_i,
   input  logic             lane_mismatch_i,
   input  logic             cpl_i,
   input  logic [PTR_W-1:0] cpl_tag_i,
   output logic             stall_o,
   output logic             wait_done_o,
   output logic [OCC_W-1:0] pending_o,
   output logic             full_o,
   output logic             err_o
);
   import agt_pkg::*;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] open_q;
   logic [CNT_W-1:0] open_sum;
   logic             commit_ok, wait_ok, active, cond;
   logic [OCC_W-1:0] n_q, n_eff, occ;
   wait_state_e      st_q;
   logic             err_q;

   logic [DEPTH-1:0] slot_vld;
   logic [CNT_W-1:0] slot_cnt [DEPTH];
   logic [PTR_W-1:0] tail;

   assign commit_ok = commit_i && !lane_mismatch_i && !full_o;
   assign wait_ok   = wait_req_i && !lane_mismatch_i && (st_q == WAIT_IDLE);
   assign open_sum  = open_q + CNT_W'(issue_i);
   assign active    = (st_q == WAIT_HOLD) || wait_ok;
   assign n_eff     = (st_q == WAIT_HOLD) ? n_q : wait_n_i;

   agt_group_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_queue (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (commit_ok),
      .push_cnt_i (open_sum),
      .cpl_i      (cpl_i),
      .cpl_tag_i  (cpl_tag_i),
      .slot_vld_o (slot_vld),
      .slot_cnt_o (slot_cnt),
      .tail_o     (tail),
      .occ_o      (occ),
      .full_o     (full_o)
   );

   agt_wait_eval #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_eval (
      .slot_vld_i (slot_vld),
      .slot_cnt_i (slot_cnt),
      .tail_i     (tail),
      .keep_n_i   (n_eff),
      .cond_o     (cond),
      .pending_o  (pending_o)
   );

   assign wait_done_o = active && cond;
   assign stall_o     = active && !cond;
   assign err_o       = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= '0;
         st_q   <= WAIT_IDLE;
         n_q    <= '0;
         err_q  <= 1'b0;
      end else begin
         open_q <= commit_ok ? '0 : open_sum;
         st_q   <= (active && !cond) ? WAIT_HOLD : WAIT_IDLE;
         if (wait_ok) n_q <= wait_n_i;
         if (lane_mismatch_i && (commit_i || wait_req_i)) err_q <= 1'b1;
      end
   end

   // R6: a stall ends only in further stall or in the done pulse
   a_r6_stall_resolves: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |=> (stall_o || wait_done_o));
   // R9: the error flag never clears
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);
   // R10: pending groups never outnumber occupied slots
   a_r10_pending_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      pending_o <= occ);
   // R1: the open tally must not wrap
   a_r1_open_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_i && !commit_ok && (&open_q)));
endmodule

// File: tb/async_group_tracker_tb.sv
`timescale 1ns/1ps
module async_group_tracker_tb;
   localparam int DEPTH = 8;
   localparam int CNT_W = 6;
   localparam int PTR_W = $clog2(DEPTH);
   localparam int OCC_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic issue_i = 0, commit_i = 0, wait_req_i = 0, lane_mismatch_i = 0, cpl_i = 0;
   logic [OCC_W-1:0] wait_n_i = '0;
   logic [PTR_W-1:0] cpl_tag_i = '0;
   logic stall_o, wait_done_o, full_o, err_o;
   logic [OCC_W-1:0] pending_o;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   async_group_tracker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .commit_i(commit_i),
      .wait_req_i(wait_req_i), .wait_n_i(wait_n_i), .lane_mismatch_i(lane_mismatch_i),
      .cpl_i(cpl_i), .cpl_tag_i(cpl_tag_i), .stall_o(stall_o), .wait_done_o(wait_done_o),
      .pending_o(pending_o), .full_o(full_o), .err_o(err_o));

   typedef struct packed {
      logic       iss, com, wr;
      logic [3:0] n;
      logic       cpl;
      logic [2:0] tag;
      logic       e_stall, e_done;
      logic [3:0] e_pend;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b0,1'b0,4'd0,1'b0,3'd0,1'b0,1'b0,4'd0}, // idle
      '{1'b1,1'b0,1'b0,4'd0,1'b0,3'd0,1'b0,1'b0,4'd0}, // R10 issue
      '{1'b1,1'b0,1'b0,4'd0,1'b0,3'd0,1'b0,1'b0,4'd0}, // R10 uncommitted not pending
      '{1'b0,1'b1,1'b0,4'd0,1'b0,3'd0,1'b0,1'b0,4'd0}, // R1 commit -> slot0 cnt2
      '{1'b1,1'b0,1'b0,4'd0,1'b0,3'd0,1'b0,1'b0,4'd1}, // pending 1
      '{1'b0,1'b1,1'b0,4'd0,1'b0,3'd0,1'b0,1'b0,4'd1}, // commit -> slot1 cnt1
      '{1'b0,1'b0,1'b1,4'd1,1'b0,3'd0,1'b1,1'b0,4'd2}, // R3 older pending blocks
      '{1'b0,1'b0,1'b0,4'd0,1'b1,3'd1,1'b1,1'b0,4'd2}, // R8 younger completes
      '{1'b0,1'b0,1'b0,4'd0,1'b1,3'd0,1'b1,1'b0,4'd1}, // R8 younger kept, stall
      '{1'b0,1'b0,1'b0,4'd0,1'b0,3'd0,1'b1,1'b0,4'd1}, // R6 still stalled
      '{1'b0,1'b0,1'b0,4'd0,1'b1,3'd0,1'b1,1'b0,4'd1}, // last op of slot0
      '{1'b0,1'b0,1'b0,4'd0,1'b0,3'd0,1'b0,1'b1,4'd0}, // R5 done pulse
      '{1'b0,1'b0,1'b1,4'd0,1'b0,3'd0,1'b0,1'b1,4'd0}, // R5 same-cycle done
      '{1'b0,1'b1,1'b0,4'd0,1'b0,3'd0,1'b0,1'b0,4'd0}, // R2 empty commit slot2
      '{1'b0,1'b0,1'b1,4'd0,1'b0,3'd0,1'b0,1'b1,4'd0}, // R2 empty group complete
      '{1'b1,1'b1,1'b0,4'd0,1'b0,3'd0,1'b0,1'b0,4'd0}, // R1 same-cycle issue -> slot3 cnt1
      '{1'b0,1'b0,1'b1,4'd1,1'b0,3'd0,1'b0,1'b1,4'd1}, // R3 newest may stay pending
      '{1'b0,1'b0,1'b1,4'd0,1'b0,3'd0,1'b1,1'b0,4'd1}, // R4 wait(0) blocks
      '{1'b0,1'b0,1'b0,4'd0,1'b1,3'd3,1'b1,1'b0,4'd1}, // R11 tag 3
      '{1'b0,1'b0,1'b0,4'd0,1'b0,3'd0,1'b0,1'b1,4'd0}  // R4 done
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input logic iss, input logic com, input logic wr, input int n,
                      input logic cpl, input int tag, input logic mm);
      @(negedge clk);
      issue_i = iss; commit_i = com; wait_req_i = wr; wait_n_i = OCC_W'(n);
      cpl_i = cpl; cpl_tag_i = PTR_W'(tag); lane_mismatch_i = mm;
      #2;
   endtask

   initial begin
      #(8 * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #2;
      chk(stall_o == 0 && wait_done_o == 0, "R6 reset", stall_o, 0);
      chk(pending_o == 0 && full_o == 0 && err_o == 0, "R10 reset", pending_o, 0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         cyc(VECS[v].iss, VECS[v].com, VECS[v].wr, int'(VECS[v].n),
             VECS[v].cpl, int'(VECS[v].tag), 1'b0);
         chk(stall_o == VECS[v].e_stall, $sformatf("R6 stall vec %0d", v), stall_o, VECS[v].e_stall);
         chk(wait_done_o == VECS[v].e_done, $sformatf("R5 done vec %0d", v), wait_done_o, VECS[v].e_done);
         chk(pending_o == OCC_W'(VECS[v].e_pend), $sformatf("R10 pending vec %0d", v),
             pending_o, VECS[v].e_pend);
      end

      // R7: fill the queue; one pending group at slot 4 then seven empty groups
      cyc(1, 0, 0, 0, 0, 0, 0);
      cyc(0, 1, 0, 0, 0, 0, 0);
      for (int k = 0; k < 7; k++) cyc(0, 1, 0, 0, 0, 0, 0);
      cyc(1, 1, 0, 0, 0, 0, 0); // refused commit, issue stays open
      chk(full_o == 1, "R7 full", full_o, 1);
      chk(pending_o == 1, "R8 empties wait behind head", pending_o, 1);
      cyc(0, 0, 0, 0, 1, 6, 0); // R11 completion to zero-count slot
      chk(full_o == 1, "R7 refused commit", full_o, 1);
      chk(pending_o == 1, "R7 refused commit", pending_o, 1);
      cyc(0, 0, 0, 0, 1, 4, 0);
      chk(pending_o == 1, "R11 ignored completion", pending_o, 1);
      cyc(0, 0, 1, 0, 0, 0, 0);
      chk(wait_done_o == 1 && stall_o == 0, "R4 drained", wait_done_o, 1);
      for (int k = 0; k < 9; k++) cyc(0, 0, 0, 0, 0, 0, 0);
      chk(full_o == 0, "R8 drained one per cycle", full_o, 0);
      cyc(0, 1, 0, 0, 0, 0, 0); // carried-over op -> slot 4
      cyc(0, 0, 0, 0, 0, 0, 0);
      chk(pending_o == 1, "R1 refused op carried over", pending_o, 1);
      cyc(0, 0, 0, 0, 1, 4, 0);
      cyc(0, 0, 0, 0, 0, 0, 0);
      chk(pending_o == 0, "R11 slot wrap tag", pending_o, 0);

      // R9: non-uniform requests
      cyc(1, 0, 0, 0, 0, 0, 0);
      cyc(0, 1, 0, 0, 0, 0, 1);
      chk(err_o == 0, "R9 err latency", err_o, 0);
      cyc(0, 0, 0, 0, 0, 0, 0);
      chk(err_o == 1, "R9 err set", err_o, 1);
      cyc(0, 0, 1, 0, 0, 0, 1);
      chk(wait_done_o == 0 && stall_o == 0, "R9 wait dropped", wait_done_o, 0);
      cyc(0, 1, 0, 0, 0, 0, 0); // open op from dropped commit
      cyc(0, 0, 0, 0, 0, 0, 0);
      chk(pending_o == 1, "R9 commit dropped, op kept", pending_o, 1);
      chk(err_o == 1, "R9 sticky", err_o, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule